// File: doc/BRIEF.md
# Rename Stage Stall and Skid Controller

This block holds the flow-control logic of a multi-slot register-rename stage. Each cycle, decode offers a group of up to `W` instructions. Each slot carries a valid bit and a count of the destination registers it needs. The controller decides how many of those slots may leave rename in this cycle. The limit is the smallest of four things:

- the slot width;
- the free reorder-buffer entries;
- the free issue-queue entries;
- the free physical registers, spent in slot order.

The register translation itself is outside this block. Only the per-slot grant and the stall line back to decode are produced here.

When a downstream stall or a lack of space stops a group, the slots not yet renamed are held in a four-group skid FIFO, and the stage enters a blocked state. Every valid group that decode keeps sending during that time is also queued. Once both stall flags are clear and both free counts are nonzero, the stage replays the queued groups oldest first. During replay, input from decode is ignored. It then resumes taking live groups. A squash from commit, or a reorder-buffer unwind, overrides everything: the FIFO is discarded and the stage waits until both indications drop.

The state machine has five states. Idle is the state after reset. Running accepts live groups. Blocked captures groups. Unblocking replays from the FIFO. Squashing waits out a squash or unwind. The stall to decode is high exactly while the registered state is Blocked or Unblocking.

Top module: `rn_stall_skid_ctrl`

## Requirements
- R1: After synchronous active-low reset, `stall_up` is 0, `out_valid` is 0 and the skid FIFO is empty.
- R2: The slot valid encoding is: bit k of `grp_in_valid` or `out_valid` stands for slot k. Input groups are a contiguous prefix starting at slot 0. In Idle or Running, with both stall flags clear and a live group present, `out_valid` grants a contiguous prefix of the valid slots. Its length is at most min(W, `rob_free`, `iq_free`), and the output appears in the same cycle.
- R3: Slot k requests the destination count held in `grp_in_ndst[k*DW +: DW]`. Granting proceeds in slot order while the running sum of granted destination counts stays within `preg_free`. It stops at the first slot whose count exceeds what remains.
- R4: With a live group present and `rob_free` or `iq_free` equal to zero, nothing is granted. The whole group enters the FIFO, and `stall_up` is 1 from the next cycle.
- R5: With `issue_stall` or `commit_stall` high in Idle, Running or Unblocking, nothing is granted and the stage goes to Blocked. In Idle or Running, a live group present in that cycle is queued.
- R6: When only part of a group is granted, the remaining slots are shifted down so that the first ungranted slot becomes slot 0. They are queued (from Running), or they replace the FIFO head (from Unblocking), and the stage goes to Blocked.
- R7: In Blocked, `out_valid` is 0, every valid incoming group is queued, and `stall_up` stays 1.
- R8: Blocked leaves only in a cycle where both stall flags are low and both free counts are nonzero. It goes to Unblocking if the FIFO then holds or receives a group, and to Running otherwise. Unblocking grants from the head group under R2 and R3 and ignores live input. It pops the head when the head is fully granted, and returns to Running after the last pop.
- R9: `flush_req` or `rob_unwinding` in any state empties the FIFO, grants nothing and enters Squashing, where `stall_up` is 0. Squashing grants nothing. It goes to Running in the first cycle in which both indications are low.
- R10: The FIFO holds up to 4 groups and replays them in arrival order. A push is never made when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_in_valid | input | W | Slot valid bits of the decode group |
| grp_in_ndst | input | W*DW | Per-slot destination register counts |
| issue_stall | input | 1 | Stall request from the issue side |
| commit_stall | input | 1 | Stall request from commit |
| rob_free | input | CW | Free reorder-buffer entries |
| iq_free | input | CW | Free issue-queue entries |
| preg_free | input | CW | Free physical registers |
| flush_req | input | 1 | Squash request from commit |
| rob_unwinding | input | 1 | Reorder buffer still squashing |
| out_valid | output | W | Slots granted to leave rename this cycle |
| stall_up | output | 1 | Stall towards decode |

## Verification
The assertions assume the following about the inputs:
- decode offers only slot-0-anchored contiguous valid masks;
- decode never sends a valid group while Blocked with four groups already queued;
- no push and no pop or head rewrite happen together on the FIFO.

The stimulus meets these assumptions by drawing valid masks only as prefixes. It also consults the bench's own model of the queue occupancy and sends an empty group whenever the model is Blocked with a full queue. All other inputs, including stall flags, zero free counts and squash pulses, are drawn freely.

// File: rtl/rn_ctrl_pkg.sv
// Package: shared state encoding for the rename stall/skid controller.
// Assumes nothing beyond being compiled before the modules using it.
package rn_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCK   = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } rn_state_e;
endpackage

// File: rtl/rn_grant_calc.sv
// Module: computes the in-order slot grant for one group under the
// width, ROB, IQ and physical-register limits, plus the shifted tail.
// Assumes grp_valid is a contiguous prefix starting at slot 0.
module rn_grant_calc #(
    parameter int W  = 4,
    parameter int DW = 2,
    parameter int CW = 6
) (
    input  logic [W-1:0]    grp_valid,
    input  logic [W*DW-1:0] grp_ndst,
    input  logic [CW-1:0]   rob_free,
    input  logic [CW-1:0]   iq_free,
    input  logic [CW-1:0]   preg_free,
    output logic [W-1:0]    grant,
    output logic [W-1:0]    rem_valid,
    output logic [W*DW-1:0] rem_ndst,
    output logic            partial
);
    localparam int NW = $clog2(W + 1);

    logic [CW:0]   budget;
    logic [CW:0]   need;
    logic          halted;
    logic [NW-1:0] taken;
    int            cap;

    // Walk slots in order, granting while every limit still allows it.
    always_comb begin
        cap = W;
        if (int'(rob_free) < cap) cap = int'(rob_free);
        if (int'(iq_free) < cap)  cap = int'(iq_free);
        budget = {1'b0, preg_free};
        halted = 1'b0;
        taken  = '0;
        grant  = '0;
        need   = '0;
        for (int k = 0; k < W; k++) begin
            need = (CW + 1)'(grp_ndst[k*DW +: DW]);
            if (!halted && grp_valid[k] && (k < cap) && (need <= budget)) begin
                grant[k] = 1'b1;
                budget   = budget - need;
                taken    = taken + 1'b1;
            end else begin
                halted = 1'b1;
            end
        end
        rem_valid = grp_valid >> taken;
        rem_ndst  = grp_ndst >> (taken * DW);
        partial   = |rem_valid;
    end
endmodule

// File: rtl/rn_skid_fifo.sv
// Module: skid FIFO of whole instruction groups (valid mask + per-slot
// destination counts) with flush and an in-place head rewrite.
// Assumes callers never push when full, never pop/rewrite when empty,
// and never push in the same cycle as a pop or rewrite.
module rn_skid_fifo #(
    parameter int W     = 4,
    parameter int DW    = 2,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SCW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [W-1:0]    push_valid,
    input  logic [W*DW-1:0] push_ndst,
    input  logic            pop,
    input  logic            head_wr,
    input  logic [W-1:0]    head_wr_valid,
    input  logic [W*DW-1:0] head_wr_ndst,
    output logic [W-1:0]    head_valid,
    output logic [W*DW-1:0] head_ndst,
    output logic [SCW-1:0]  count
);
    logic [W-1:0]    mem_v [DEPTH];
    logic [W*DW-1:0] mem_n [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;

    // Advance a pointer with explicit wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Group storage: tail write on push, head rewrite on partial replay.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem_v[wr_ptr] <= push_valid;
            mem_n[wr_ptr] <= push_ndst;
        end else if (head_wr && !flush) begin
            mem_v[rd_ptr] <= head_wr_valid;
            mem_n[rd_ptr] <= head_wr_ndst;
        end
    end

    assign head_valid = mem_v[rd_ptr];
    assign head_ndst  = mem_n[rd_ptr];

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < SCW'(DEPTH)));
    assert_no_push_with_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && (pop || head_wr)));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || head_wr) |-> (count != '0));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/rn_stall_skid_ctrl.sv
// Module: rename-stage flow controller. Grants slots of the live or
// replayed group, steers the Idle/Running/Blocked/Unblocking/Squashing
// state machine, queues stopped groups and stalls decode.
// Assumes live valid masks are slot-0 prefixes and that decode sends no
// valid group while Blocked with a full skid FIFO.
module rn_stall_skid_ctrl
    import rn_ctrl_pkg::*;
#(
    parameter int W          = 4,
    parameter int DW         = 2,
    parameter int CW         = 6,
    parameter int SKID_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    grp_in_valid,
    input  logic [W*DW-1:0] grp_in_ndst,
    input  logic            issue_stall,
    input  logic            commit_stall,
    input  logic [CW-1:0]   rob_free,
    input  logic [CW-1:0]   iq_free,
    input  logic [CW-1:0]   preg_free,
    input  logic            flush_req,
    input  logic            rob_unwinding,
    output logic [W-1:0]    out_valid,
    output logic            stall_up
);
    localparam int SCW = $clog2(SKID_DEPTH + 1);

    rn_state_e       state, nxt;
    logic            any_squash, ds_stall, no_space, live_has;
    logic [W-1:0]    src_valid, grant, rem_valid, head_valid;
    logic [W*DW-1:0] src_ndst, rem_ndst, head_ndst;
    logic            partial;
    logic            push, pop, head_wr, flush, use_rem;
    logic [SCW-1:0]  skid_cnt;

    assign any_squash = flush_req | rob_unwinding;
    assign ds_stall   = issue_stall | commit_stall;
    assign no_space   = (rob_free == '0) || (iq_free == '0);
    assign live_has   = |grp_in_valid;

    // Group source: FIFO head while replaying, decode otherwise.
    assign src_valid = (state == ST_UNBLOCK) ? head_valid : grp_in_valid;
    assign src_ndst  = (state == ST_UNBLOCK) ? head_ndst  : grp_in_ndst;

    rn_grant_calc #(.W(W), .DW(DW), .CW(CW)) u_grant (
        .grp_valid (src_valid),
        .grp_ndst  (src_ndst),
        .rob_free  (rob_free),
        .iq_free   (iq_free),
        .preg_free (preg_free),
        .grant     (grant),
        .rem_valid (rem_valid),
        .rem_ndst  (rem_ndst),
        .partial   (partial)
    );

    rn_skid_fifo #(.W(W), .DW(DW), .DEPTH(SKID_DEPTH)) u_skid (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .push          (push),
        .push_valid    (use_rem ? rem_valid : grp_in_valid),
        .push_ndst     (use_rem ? rem_ndst  : grp_in_ndst),
        .pop           (pop),
        .head_wr       (head_wr),
        .head_wr_valid (rem_valid),
        .head_wr_ndst  (rem_ndst),
        .head_valid    (head_valid),
        .head_ndst     (head_ndst),
        .count         (skid_cnt)
    );

    // Next-state, grant and FIFO-control decision for this cycle.
    always_comb begin
        nxt       = state;
        out_valid = '0;
        push      = 1'b0;
        pop       = 1'b0;
        head_wr   = 1'b0;
        flush     = 1'b0;
        use_rem   = 1'b0;
        if (any_squash) begin
            flush = 1'b1;
            nxt   = ST_SQUASH;
        end else begin
            case (state)
                ST_IDLE, ST_RUN: begin
                    if (ds_stall) begin
                        push = live_has;
                        nxt  = ST_BLOCK;
                    end else if (live_has) begin
                        if (no_space) begin
                            push = 1'b1;
                            nxt  = ST_BLOCK;
                        end else begin
                            out_valid = grant;
                            if (partial) begin
                                push    = 1'b1;
                                use_rem = 1'b1;
                                nxt     = ST_BLOCK;
                            end else begin
                                nxt = ST_RUN;
                            end
                        end
                    end
                end
                ST_BLOCK: begin
                    push = live_has;
                    if (!ds_stall && !no_space)
                        nxt = (skid_cnt == '0 && !live_has) ? ST_RUN : ST_UNBLOCK;
                end
                ST_UNBLOCK: begin
                    if (ds_stall || no_space) begin
                        nxt = ST_BLOCK;
                    end else begin
                        out_valid = grant;
                        if (partial) begin
                            head_wr = 1'b1;
                            nxt     = ST_BLOCK;
                        end else begin
                            pop = 1'b1;
                            nxt = (skid_cnt == SCW'(1)) ? ST_RUN : ST_UNBLOCK;
                        end
                    end
                end
                default: nxt = ST_RUN;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign stall_up = (state == ST_BLOCK) || (state == ST_UNBLOCK);

    assert_grant_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & (out_valid + 1'b1)) == '0);
    assert_grant_rob_iq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_valid) <= int'(rob_free)) && ($countones(out_valid) <= int'(iq_free)));
    assert_no_space_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        no_space |-> (out_valid == '0));
    assert_ds_stall_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ds_stall |-> (out_valid == '0));
    assert_blocked_holds_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_up && ds_stall && !any_squash) |=> stall_up);
    assert_squash_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_squash |=> (!stall_up && out_valid == '0));
    assert_input_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_in_valid & (grp_in_valid + 1'b1)) == '0);
endmodule

// File: tb/rn_stall_skid_ctrl_tb_top.sv
module rn_stall_skid_ctrl_tb_top;
    localparam int W = 4, DW = 2, CW = 6, DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]    g_v = '0;
    logic [W*DW-1:0] g_n = '0;
    logic is_st = 0, cm_st = 0, sq = 0, rsq = 0;
    logic [CW-1:0] rob = '0, iq = '0, preg = '0;
    logic [W-1:0] out_valid;
    logic stall_up;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rn_stall_skid_ctrl #(.W(W), .DW(DW), .CW(CW), .SKID_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .grp_in_valid(g_v), .grp_in_ndst(g_n),
        .issue_stall(is_st), .commit_stall(cm_st), .rob_free(rob), .iq_free(iq),
        .preg_free(preg), .flush_req(sq), .rob_unwinding(rsq),
        .out_valid(out_valid), .stall_up(stall_up));

    // Reference model: 0 idle, 1 run, 2 blocked, 3 unblocking, 4 squashing
    int m_state = 0, nx_state = 0;
    logic [W-1:0]    q_v[$];
    logic [W*DW-1:0] q_n[$];
    bit a_push, a_pop, a_hw, a_flush;
    logic [W-1:0] a_v;
    logic [W*DW-1:0] a_n;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void grant_of(input logic [W-1:0] v, input logic [W*DW-1:0] n,
                                     output logic [W-1:0] g, output int taken, output bit reg_lim);
        int lim, left, d;
        lim = W;
        if (int'(rob) < lim) lim = int'(rob);
        if (int'(iq) < lim) lim = int'(iq);
        left = int'(preg);
        taken = 0; g = '0; reg_lim = 0;
        while (taken < lim && v[taken]) begin
            d = int'(n[taken*DW +: DW]);
            if (d > left) begin reg_lim = 1; break; end
            left -= d;
            g[taken] = 1'b1;
            taken++;
        end
    endfunction

    // Evaluate the model for the current inputs and compare both outputs.
    task automatic eval_and_check();
        logic [W-1:0] exp_out, g;
        int taken;
        bit reg_lim, ds, nsp, live;
        string tag;
        exp_out = '0; a_push = 0; a_pop = 0; a_hw = 0; a_flush = 0;
        a_v = g_v; a_n = g_n; nx_state = m_state;
        ds = is_st | cm_st; nsp = (rob == 0) || (iq == 0); live = |g_v;
        tag = "R2";
        check((m_state == 2 || m_state == 3) ? "R7" : (m_state == 4 ? "R9" : "R4"),
              "stall_up", int'(stall_up), (m_state == 2 || m_state == 3) ? 1 : 0);
        if (sq || rsq) begin
            a_flush = 1; nx_state = 4; tag = "R9";
        end else if (m_state <= 1) begin
            if (ds) begin a_push = live; nx_state = 2; tag = "R5"; end
            else if (live) begin
                if (nsp) begin a_push = 1; nx_state = 2; tag = "R4"; end
                else begin
                    grant_of(g_v, g_n, exp_out, taken, reg_lim);
                    if (reg_lim) tag = "R3";
                    if ((g_v >> taken) != '0) begin
                        a_push = 1; a_v = g_v >> taken; a_n = g_n >> (taken * DW);
                        nx_state = 2; if (!reg_lim) tag = "R6";
                    end else nx_state = 1;
                end
            end
        end else if (m_state == 2) begin
            tag = "R7"; a_push = live;
            if (!ds && !nsp) nx_state = (q_v.size() == 0 && !live) ? 1 : 3;
        end else if (m_state == 3) begin
            tag = "R8_R10";
            if (ds || nsp) nx_state = 2;
            else begin
                grant_of(q_v[0], q_n[0], g, taken, reg_lim);
                exp_out = g;
                if ((q_v[0] >> taken) != '0) begin
                    a_hw = 1; a_v = q_v[0] >> taken; a_n = q_n[0] >> (taken * DW);
                    nx_state = 2; tag = "R6";
                end else begin
                    a_pop = 1; nx_state = (q_v.size() == 1) ? 1 : 3;
                end
            end
        end else begin
            tag = "R9"; nx_state = 1;
        end
        check(tag, "out_valid", int'(out_valid), int'(exp_out));
    endtask

    task automatic commit_model();
        if (a_flush) begin q_v.delete(); q_n.delete(); end
        if (a_push) begin q_v.push_back(a_v); q_n.push_back(a_n); end
        if (a_pop) begin void'(q_v.pop_front()); void'(q_n.pop_front()); end
        if (a_hw) begin q_v[0] = a_v; q_n[0] = a_n; end
        m_state = nx_state;
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic step();
        #8;
        eval_and_check();
        @(posedge clk);
        commit_model();
        @(negedge clk);
    endtask

    task automatic drive(input int len, input logic [W*DW-1:0] n, input int r, input int i,
                         input int p, input bit s1, input bit s2, input bit f1, input bit f2);
        g_v = W'((1 << len) - 1); g_n = n;
        rob = CW'(r); iq = CW'(i); preg = CW'(p);
        is_st = s1; cm_st = s2; sq = f1; rsq = f2;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        #8;
        check("R1", "stall_up after reset", int'(stall_up), 0);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        @(negedge clk);
        // R2: full-width grant
        drive(4, 8'h55, 8, 8, 8, 0, 0, 0, 0);
        // R2: ROB limits to two, tail queued (R6), then replayed
        drive(3, 8'h15, 2, 8, 8, 0, 0, 0, 0);
        drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        // R3: register budget stops at slot 1
        drive(4, 8'hAA, 8, 8, 3, 0, 0, 0, 0);
        drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        // R4 + R7 + R10: fill the FIFO with four groups, then replay in order
        drive(1, 8'h01, 0, 8, 8, 0, 0, 0, 0);
        drive(2, 8'h05, 8, 8, 8, 1, 0, 0, 0);
        drive(3, 8'h15, 8, 8, 8, 0, 1, 0, 0);
        drive(4, 8'h55, 8, 0, 8, 0, 0, 0, 0);
        drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) drive(0, 0, 8, 8, 8, 0, 0, 0, 0);
        // R5 + R9: stall then squash with wind-down
        drive(2, 0, 8, 8, 8, 1, 0, 0, 0);
        drive(2, 0, 8, 8, 8, 0, 0, 1, 0);
        drive(2, 0, 8, 8, 8, 0, 0, 0, 1);
        drive(2, 0, 8, 8, 8, 0, 0, 0, 0);
        drive(2, 0, 8, 8, 8, 0, 0, 0, 0);
        // Random phase
        for (int c = 0; c < 6000; c++) begin
            logic [W*DW-1:0] n;
            len = $urandom_range(0, W);
            if (m_state == 2 && q_v.size() >= DEPTH) len = 0;
            n = '0;
            for (int k = 0; k < W; k++) n[k*DW +: DW] = DW'($urandom_range(0, 2));
            drive(len, n, $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 7),
                  ($urandom_range(0, 6) == 0), ($urandom_range(0, 6) == 0),
                  ($urandom_range(0, 25) == 0), ($urandom_range(0, 25) == 0));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule